// File: doc/BRIEF.md
# APB Slave-Select Fabric with Gated-OR Readback

This block joins one APB requester to a fixed set of completers, each on its own point-to-point port. Every request signal that leaves the requester (select, enable, write flag, write data) is copied onto every completer port. The byte address is compared against one wildcard pattern per completer. Each pattern is a value plus a care mask, and a mask bit of zero makes that address bit a don't-care. The matching completer gets its select, and only while the requester's select is high.

Each completer is handed only the short word-offset slice of the address that its own window needs. The default slice is four bits, taken from byte-address bits 5 down to 2, which covers a 16-word window. Read data travels the other way. Every completer whose select is low has its read data forced to zero, and all completer read data are then ORed into the requester's read data. No shared net and no three-state driver are used. The path from request to completer select, and from completer read data back to the requester, has no register on it. A normal two-cycle APB transfer therefore reaches the chosen completer with its setup and access phases unchanged.

Top module: `apbf_fabric`

## Requirements
- R1: In every cycle, each completer port carries the requester's enable, write flag and write data unchanged. Completer k takes write data from bits [k*DW +: DW] of the flattened bus.
- R2: Completer k receives address bits [SLICE_LO+SLICE_W-1:SLICE_LO] on bits [k*SLICE_W +: SLICE_W] of its address bus. With the defaults these are byte-address bits [5:2].
- R3: Completer k's select is high exactly when the requester's select is high and (address AND CARE_k) equals (VAL_k AND CARE_k). CARE_k and VAL_k are bits [k*AW +: AW] of the mask and value parameters.
- R4: With non-overlapping patterns, at most one completer select is high at any time.
- R5: While completer k is selected, the requester's read data equals completer k's read data. Read data driven by unselected completers has no effect on it.
- R6: When no pattern matches, or the requester's select is low, every completer select is low and the requester reads all zeros.
- R7: Select and enable reach the completer in the same cycle as they leave the requester. A setup cycle (select high, enable low) followed by an access cycle writes to, or reads from, the addressed word of the matching completer.
- R8: Address bits that are don't-care in a completer's pattern do not affect the decode. Two addresses that differ only in such bits reach the same completer and the same word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| m_psel | input | 1 | Requester select |
| m_penable | input | 1 | Requester enable (access phase) |
| m_pwrite | input | 1 | Requester write flag |
| m_paddr | input | AW | Requester byte address |
| m_pwdata | input | DW | Requester write data |
| m_prdata | output | DW | Read data returned to requester |
| s_psel | output | N_SLV | Per-completer select, one bit each |
| s_penable | output | N_SLV | Per-completer enable |
| s_pwrite | output | N_SLV | Per-completer write flag |
| s_paddr | output | N_SLV*SLICE_W | Per-completer word-offset slice |
| s_pwdata | output | N_SLV*DW | Per-completer write data |
| s_prdata | input | N_SLV*DW | Per-completer read data |

## Verification
The bench builds the fabric with four completers, 32-bit address and data, and a 4-bit slice at bit 2. Three completers use fully specified 16-word windows at 0x4000_0000, 0x4000_1000 and 0x4000_2000. The fourth uses a mask that ignores address bits 27:12, so many different addresses alias onto one window and the don't-care path (R8) can be tested. The completer models in the bench always drive their read data, even when not selected, so a missing zero gate shows up as corrupted readback. Random addresses are mixed from in-window hits, aliased hits, one-bit near misses and unmapped values, which reaches both the match boundary and the all-zero case.

// File: rtl/apbf_pkg.sv
package apbf_pkg;

  // Wildcard compare: a zero in care marks a don't-care address bit.
  function automatic logic wild_hit(input logic [63:0] addr,
                                    input logic [63:0] val,
                                    input logic [63:0] care);
    return ((addr ^ val) & care) == 64'd0;
  endfunction

endpackage

// File: rtl/apbf_decode.sv
module apbf_decode #(
  parameter int                    N_SLV      = 4,
  parameter int                    AW         = 32,
  parameter logic [N_SLV*AW-1:0]   MATCH_VAL  = '0,
  parameter logic [N_SLV*AW-1:0]   MATCH_CARE = '0
) (
  input  logic              req_sel,
  input  logic [AW-1:0]     req_addr,
  output logic [N_SLV-1:0]  tgt_sel
);
  import apbf_pkg::*;

  localparam int PADW = 64 - AW;

  for (genvar k = 0; k < N_SLV; k++) begin : g_cmp
    logic [AW-1:0] val_k;
    logic [AW-1:0] care_k;
    logic          hit_k;
    assign val_k  = MATCH_VAL[k*AW +: AW];
    assign care_k = MATCH_CARE[k*AW +: AW];
    assign hit_k  = wild_hit({{PADW{1'b0}}, req_addr},
                             {{PADW{1'b0}}, val_k},
                             {{PADW{1'b0}}, care_k});
    assign tgt_sel[k] = req_sel & hit_k;
  end

endmodule

// File: rtl/apbf_rdmux.sv
module apbf_rdmux #(
  parameter int N_SLV = 4,
  parameter int DW    = 32
) (
  input  logic [N_SLV-1:0]    tgt_sel,
  input  logic [N_SLV*DW-1:0] tgt_rdata,
  output logic [DW-1:0]       req_rdata
);

  logic [DW-1:0] gated [N_SLV];

  for (genvar k = 0; k < N_SLV; k++) begin : g_gate
    assign gated[k] = tgt_rdata[k*DW +: DW] & {DW{tgt_sel[k]}};
  end

  always_comb begin
    req_rdata = '0;
    for (int k = 0; k < N_SLV; k++) begin
      req_rdata = req_rdata | gated[k];
    end
  end

endmodule

// File: rtl/apbf_fabric.sv
module apbf_fabric #(
  parameter int                    N_SLV      = 4,
  parameter int                    AW         = 32,
  parameter int                    DW         = 32,
  parameter int                    SLICE_LO   = 2,
  parameter int                    SLICE_W    = 4,
  parameter logic [N_SLV*AW-1:0]   MATCH_VAL  = {32'h5000_0000, 32'h4000_2000,
                                                 32'h4000_1000, 32'h4000_0000},
  parameter logic [N_SLV*AW-1:0]   MATCH_CARE = {32'hF000_0FC0, 32'hFFFF_FFC0,
                                                 32'hFFFF_FFC0, 32'hFFFF_FFC0}
) (
  input  logic                     m_psel,
  input  logic                     m_penable,
  input  logic                     m_pwrite,
  input  logic [AW-1:0]            m_paddr,
  input  logic [DW-1:0]            m_pwdata,
  output logic [DW-1:0]            m_prdata,
  output logic [N_SLV-1:0]         s_psel,
  output logic [N_SLV-1:0]         s_penable,
  output logic [N_SLV-1:0]         s_pwrite,
  output logic [N_SLV*SLICE_W-1:0] s_paddr,
  output logic [N_SLV*DW-1:0]      s_pwdata,
  input  logic [N_SLV*DW-1:0]      s_prdata
);

  localparam int SLICE_HI = SLICE_LO + SLICE_W - 1;

  logic [SLICE_W-1:0] word_off;
  assign word_off = m_paddr[SLICE_HI:SLICE_LO];

  apbf_decode #(
    .N_SLV(N_SLV), .AW(AW), .MATCH_VAL(MATCH_VAL), .MATCH_CARE(MATCH_CARE)
  ) u_decode (
    .req_sel  (m_psel),
    .req_addr (m_paddr),
    .tgt_sel  (s_psel)
  );

  for (genvar k = 0; k < N_SLV; k++) begin : g_port
    assign s_penable[k]                = m_penable;
    assign s_pwrite[k]                 = m_pwrite;
    assign s_paddr[k*SLICE_W +: SLICE_W] = word_off;
    assign s_pwdata[k*DW +: DW]        = m_pwdata;
  end

  apbf_rdmux #(.N_SLV(N_SLV), .DW(DW)) u_rdmux (
    .tgt_sel   (s_psel),
    .tgt_rdata (s_prdata),
    .req_rdata (m_prdata)
  );

endmodule

// File: rtl/apbf_fabric_chk.sv
module apbf_fabric_chk #(
  parameter int N_SLV = 4,
  parameter int DW    = 32
) (
  input logic                m_psel,
  input logic [DW-1:0]       m_prdata,
  input logic [N_SLV-1:0]    s_psel,
  input logic [N_SLV*DW-1:0] s_prdata
);

  always_comb begin
    if (!$isunknown(s_psel)) begin
      p_sel_onehot_r4: assert ($onehot0(s_psel))
        else $error("completer selects not one-hot-or-zero");
    end
    if (!$isunknown({s_psel, m_psel})) begin
      p_sel_needs_req_r3: assert (!(|s_psel) || m_psel)
        else $error("completer selected while requester idle");
    end
    if (!$isunknown({s_psel, m_prdata})) begin
      p_idle_zero_r6: assert ((|s_psel) || (m_prdata == '0))
        else $error("nonzero readback with no completer selected");
    end
    for (int k = 0; k < N_SLV; k++) begin
      if (!$isunknown({s_psel, m_prdata, s_prdata[k*DW +: DW]}) &&
          $countones(s_psel) == 1 && s_psel[k]) begin
        p_rd_source_r5: assert (m_prdata == s_prdata[k*DW +: DW])
          else $error("readback differs from selected completer");
      end
    end
  end

endmodule

bind apbf_fabric apbf_fabric_chk #(.N_SLV(N_SLV), .DW(DW)) u_chk (
  .m_psel   (m_psel),
  .m_prdata (m_prdata),
  .s_psel   (s_psel),
  .s_prdata (s_prdata)
);

// File: tb/apbf_fabric_test.sv
`timescale 1ns/1ps
module apbf_fabric_test;

  localparam int NS = 4;
  localparam int SW = 4;
  localparam logic [31:0] TB_VAL  [NS] = '{32'h4000_0000, 32'h4000_1000,
                                           32'h4000_2000, 32'h5000_0000};
  localparam logic [31:0] TB_CARE [NS] = '{32'hFFFF_FFC0, 32'hFFFF_FFC0,
                                           32'hFFFF_FFC0, 32'hF000_0FC0};

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic              m_psel, m_penable, m_pwrite;
  logic [31:0]       m_paddr, m_pwdata, m_prdata;
  logic [NS-1:0]     s_psel, s_penable, s_pwrite;
  logic [NS*SW-1:0]  s_paddr;
  logic [NS*32-1:0]  s_pwdata, s_prdata;

  apbf_fabric #(
    .N_SLV(NS), .AW(32), .DW(32), .SLICE_LO(2), .SLICE_W(SW),
    .MATCH_VAL ({32'h5000_0000, 32'h4000_2000, 32'h4000_1000, 32'h4000_0000}),
    .MATCH_CARE({32'hF000_0FC0, 32'hFFFF_FFC0, 32'hFFFF_FFC0, 32'hFFFF_FFC0})
  ) uut (.*);

  // Completer models: 16-word registers, read data always driven.
  logic [31:0] smem [NS][16];
  always_ff @(posedge clk) begin
    for (int k = 0; k < NS; k++) begin
      for (int w = 0; w < 16; w++) begin
        if (rst) smem[k][w] <= 32'hDEAD_0000 | (k << 8) | w;
        else if (s_psel[k] && s_penable[k] && s_pwrite[k] &&
                 s_paddr[k*SW +: SW] == w[3:0])
          smem[k][w] <= s_pwdata[k*32 +: 32];
      end
    end
  end
  always_comb begin
    for (int k = 0; k < NS; k++)
      s_prdata[k*32 +: 32] = smem[k][s_paddr[k*SW +: SW]];
  end

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  task automatic chk(input bit ok, input string req,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int exp_tgt(input logic [31:0] a);
    for (int k = 0; k < NS; k++)
      if (((a ^ TB_VAL[k]) & TB_CARE[k]) == 32'd0) return k;
    return -1;
  endfunction

  function automatic logic [NS-1:0] exp_sel(input logic sel, input logic [31:0] a);
    int t;
    t = exp_tgt(a);
    exp_sel = '0;
    if (sel && t >= 0) exp_sel[t] = 1'b1;
  endfunction

  // Check all combinational paths for the current inputs.
  task automatic check_now();
    int t;
    logic [31:0] erd;
    t = exp_tgt(m_paddr);
    chk(s_psel == exp_sel(m_psel, m_paddr), "R3", 64'(s_psel),
        64'(exp_sel(m_psel, m_paddr)));
    chk($countones(s_psel) <= 1, "R4", 64'(s_psel), 64'd0);
    for (int k = 0; k < NS; k++) begin
      chk(s_penable[k] == m_penable && s_pwrite[k] == m_pwrite &&
          s_pwdata[k*32 +: 32] == m_pwdata, "R1",
          {s_penable[k], s_pwrite[k], s_pwdata[k*32 +: 32]},
          {m_penable, m_pwrite, m_pwdata});
      chk(s_paddr[k*SW +: SW] == m_paddr[5:2], "R2",
          64'(s_paddr[k*SW +: SW]), 64'(m_paddr[5:2]));
    end
    erd = (m_psel && t >= 0) ? smem[t][m_paddr[5:2]] : 32'd0;
    if (m_psel && t >= 0)
      chk(m_prdata == erd, "R5", 64'(m_prdata), 64'(erd));
    else
      chk(m_prdata == 32'd0, "R6", 64'(m_prdata), 64'd0);
  endtask

  task automatic apb_write(input logic [31:0] a, input logic [31:0] d);
    @(negedge clk);
    m_psel = 1'b1; m_penable = 1'b0; m_pwrite = 1'b1; m_paddr = a; m_pwdata = d;
    #1;
    chk(s_psel == exp_sel(1'b1, a) && s_penable == '0, "R7 setup",
        {s_psel, s_penable}, {exp_sel(1'b1, a), 4'b0});
    @(negedge clk);
    m_penable = 1'b1;
    #1;
    chk(s_psel == exp_sel(1'b1, a) && s_penable == '1, "R7 access",
        {s_psel, s_penable}, {exp_sel(1'b1, a), 4'hF});
    @(negedge clk);
    m_psel = 1'b0; m_penable = 1'b0; m_pwrite = 1'b0;
  endtask

  task automatic apb_read(input logic [31:0] a, input logic [31:0] exp, input string req);
    @(negedge clk);
    m_psel = 1'b1; m_penable = 1'b0; m_pwrite = 1'b0; m_paddr = a;
    @(negedge clk);
    m_penable = 1'b1;
    #1;
    chk(m_prdata == exp, req, 64'(m_prdata), 64'(exp));
    @(negedge clk);
    m_psel = 1'b0; m_penable = 1'b0;
  endtask

  initial begin
    void'($urandom(32'd20240611));
    m_psel = 1'b0; m_penable = 1'b0; m_pwrite = 1'b0;
    m_paddr = '0; m_pwdata = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1;
    chk(s_psel == '0 && m_prdata == '0, "R6 reset idle",
        {s_psel, m_prdata}, 64'd0);

    // R7: distinct value into every window, then read back.
    for (int k = 0; k < NS; k++) begin
      apb_write(TB_VAL[k] + 32'h0, 32'hA000_0000 | (k << 4));
      apb_write(TB_VAL[k] + 32'h3C, 32'hB000_0000 | (k << 4) | 15);
    end
    for (int k = 0; k < NS; k++) begin
      apb_read(TB_VAL[k] + 32'h0,  32'hA000_0000 | (k << 4), "R7 word0");
      apb_read(TB_VAL[k] + 32'h3C, 32'hB000_0000 | (k << 4) | 15, "R7 word15");
    end

    // R8: aliased address through don't-care bits 27:12.
    apb_write(32'h5ABC_D014, 32'h1234_5678);
    apb_read(32'h5000_0014, 32'h1234_5678, "R8 alias");
    apb_read(32'h5FFF_F017, 32'h1234_5678, "R8 alias low bits");

    // R6: unmapped and just-outside-window addresses read zero.
    apb_read(32'h4000_0040, 32'd0, "R6 past window");
    apb_read(32'h3FFF_FFFC, 32'd0, "R6 below window");
    apb_read(32'h5000_0040, 32'd0, "R6 care bit 6");
    apb_read(32'h0000_0000, 32'd0, "R6 zero address");

    // Unmapped write must not disturb any completer.
    apb_write(32'h4000_3000, 32'hFFFF_FFFF);
    apb_read(TB_VAL[0], 32'hA000_0000, "R6 stray write");

    // Random mix, checked combinationally.
    for (int i = 0; i < 400; i++) begin
      int r;
      int k;
      @(negedge clk);
      r = $urandom % 4;
      k = $urandom % NS;
      m_psel    = ($urandom % 4) != 0;
      m_penable = $urandom % 2;
      m_pwrite  = 1'b0;
      m_pwdata  = $urandom;
      case (r)
        0: m_paddr = TB_VAL[k] | ($urandom & 32'h3F);
        1: m_paddr = 32'h5000_0000 | ($urandom & 32'h0FFF_F03F);
        2: m_paddr = TB_VAL[k] ^ (32'd1 << (6 + ($urandom % 26)));
        default: m_paddr = $urandom;
      endcase
      #1;
      check_now();
    end

    @(negedge clk);
    m_psel = 1'b0; m_penable = 1'b0;
    #1;
    check_now();

    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #500000;
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

endmodule